// File: doc/BRIEF.md
# Two-Wire Switch Management Master

This block is a hardware master for a two-wire management link to an attached switch device. On the pins the link looks like a clock line and a bidirectional data line. The framing is its own and is not MDIO. The master performs 16-bit register reads and 16-bit register writes at 16-bit addresses. Each transaction opens with a two-pulse start pattern and closes with a multi-pulse stop that ends with an extra clock pulse and then releases both lines. After every byte the master sends, the device must acknowledge by pulling the data line low. A high level is polled again, up to a bounded number of times, and the transaction then aborts with an error.

The host issues one request at a time. A request carries the direction, the address, the write data and a flag that skips the final acknowledge poll. That flag is needed for a write that resets the device. The block answers with a one-cycle done pulse. With it come an error flag, and on a successful read the 16-bit result. Every pin movement is spaced by a parameterised number of system clock cycles, called the half period. The read and write command byte values are also parameters, so one netlist can serve several device variants.

Top module: `mgmt2w_master`

## Requirements
- R1: After reset both output enables are low, `busy`, `done` and `err` are low, `rdata` is zero, and `mclk_o` and `mdat_o` are low.
- R2: A request is accepted at a clock edge where `req_valid` is high and `busy` is low. Pin changes then occur only at every HALF_CYCLES-th edge after acceptance. The start pattern, with one change per slot, is: drive both lines with clock low and data high; clock high; clock low; clock high; data low; clock low; data high.
- R3: Each byte is sent MSB first, one bit per three slots: data driven to the bit value, then clock high, then clock low.
- R4: After each byte the master sends, it polls one acknowledge bit. In the first slot it releases the data line (`mdat_oe` low) and raises the clock. In the second slot it samples `mdat_i`, lowers the clock and drives data low. A sampled 0 is an acknowledge; a sampled 1 starts another poll.
- R5: If MAX_RETRY+1 consecutive polls (6 with the default) all sample 1, the master issues the stop sequence. It then pulses `done` with `err` high and leaves `rdata` unchanged.
- R6: A read sends the read command, address bits 7:0 and address bits 15:8, each acknowledged. It then receives two bytes MSB first. Each received bit takes two slots: release data and raise the clock, then sample and lower the clock. The last bit of each byte also drives data low. After the low byte the master sends one bit of value 0, and after the high byte one bit of value 1. `rdata` becomes {high byte, low byte}.
- R7: A write sends the write command, address bits 7:0, address bits 15:8, data bits 7:0 and data bits 15:8, each followed by an acknowledge poll.
- R8: A write with `req_noack` high sends its final data byte without polling an acknowledge and goes straight to the stop sequence.
- R9: The stop sequence is issued on every completion, including a timeout. Its slots are: data low with clock high; data high; clock high; clock low; clock high; clock low; clock high; release both output enables.
- R10: `busy` is high from the edge that accepts a request until the edge that releases the lines. A request presented while `busy` is high is ignored and leaves the pin activity unchanged.
- R11: `done` is high for exactly the one cycle after the release slot. `err` is high only together with `done`.
- R12: The first byte of a transaction is READ_CMD for a read and WRITE_CMD for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while not busy |
| req_read | input | 1 | 1 selects a read, 0 a write |
| req_noack | input | 1 | Skip the acknowledge poll after the final write byte |
| req_addr | input | 16 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Acknowledge timeout, valid with done |
| rdata | output | 16 | Last successful read result |
| mclk_o | output | 1 | Management clock level |
| mclk_oe | output | 1 | Management clock output enable |
| mdat_o | output | 1 | Management data level |
| mdat_oe | output | 1 | Management data output enable |
| mdat_i | input | 1 | Management data input |

## Verification
The bench builds the block with HALF_CYCLES of 2, which is the smallest spacing where the gap between pin moves is still visible. This keeps each full transaction near three hundred cycles, so several reads and writes fit in one run. MAX_RETRY stays at 5, so the run reaches both the boundary case of five refusals followed by an acknowledge and the abort after six refusals. The command values 0xA9 and 0xA8 differ only in their last bit. A read/write mix-up therefore shows on the eighth bit of the first byte.

// File: rtl/mgmt2w_pkg.sv
package mgmt2w_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int STEP_W = 3;
  localparam int IDX_W  = 3;

  // one pin action per half-period slot
  typedef enum logic [3:0] {
    ACT_NONE,
    ACT_OPEN,        // drive both lines, clock low, data high
    ACT_CLK_HI,
    ACT_CLK_LO,
    ACT_DAT_LO,
    ACT_DAT_HI,
    ACT_STOP_EDGE,   // data low and clock high together
    ACT_TX_BIT,      // drive data with the bit value
    ACT_RX_RISE,     // release data, clock high
    ACT_RX_FALL,     // clock low
    ACT_RX_FALL_DRV, // clock low, drive data low again
    ACT_RELEASE
  } pin_act_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_TX,
    ST_ACK,
    ST_RX,
    ST_MACK,
    ST_STOP
  } seq_st_e;

  typedef struct packed {
    logic              is_read;
    logic              no_ack;
    logic [WORD_W-1:0] addr;
    logic [WORD_W-1:0] wdata;
  } xfer_t;

endpackage

// File: rtl/mgmt2w_halfcnt.sv
module mgmt2w_halfcnt #(
  parameter int HALF_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run)              cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST) else $error("half-period counter out of range"); // R2

  generate
    if (HALF_CYCLES > 1) begin : g_gap
      AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick) else $error("slots closer than one half period"); // R2
    end
  endgenerate

endmodule

// File: rtl/mgmt2w_pins.sv
module mgmt2w_pins
  import mgmt2w_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  pin_act_e act,
  input  logic     act_bit,
  output logic     clk_o,
  output logic     clk_oe,
  output logic     dat_o,
  output logic     dat_oe
);
  logic clk_q, clk_d, clk_oe_q, clk_oe_d;
  logic dat_q, dat_d, dat_oe_q, dat_oe_d;

  always_comb begin
    clk_d    = clk_q;
    clk_oe_d = clk_oe_q;
    dat_d    = dat_q;
    dat_oe_d = dat_oe_q;
    if (tick) begin
      unique case (act)
        ACT_OPEN: begin
          clk_oe_d = 1'b1; dat_oe_d = 1'b1; clk_d = 1'b0; dat_d = 1'b1;
        end
        ACT_CLK_HI:    clk_d = 1'b1;
        ACT_CLK_LO:    clk_d = 1'b0;
        ACT_DAT_LO:    dat_d = 1'b0;
        ACT_DAT_HI:    dat_d = 1'b1;
        ACT_STOP_EDGE: begin dat_d = 1'b0; clk_d = 1'b1; end
        ACT_TX_BIT:    begin dat_oe_d = 1'b1; dat_d = act_bit; end
        ACT_RX_RISE:   begin dat_oe_d = 1'b0; clk_d = 1'b1; end
        ACT_RX_FALL:   clk_d = 1'b0;
        ACT_RX_FALL_DRV: begin
          clk_d = 1'b0; dat_oe_d = 1'b1; dat_d = 1'b0;
        end
        ACT_RELEASE:   begin clk_oe_d = 1'b0; dat_oe_d = 1'b0; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q    <= 1'b0;
      clk_oe_q <= 1'b0;
      dat_q    <= 1'b0;
      dat_oe_q <= 1'b0;
    end else begin
      clk_q    <= clk_d;
      clk_oe_q <= clk_oe_d;
      dat_q    <= dat_d;
      dat_oe_q <= dat_oe_d;
    end
  end

  assign clk_o  = clk_q;
  assign clk_oe = clk_oe_q;
  assign dat_o  = dat_q;
  assign dat_oe = dat_oe_q;

  AST_MOVE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(clk_q) || !$stable(dat_q) || !$stable(clk_oe_q) || !$stable(dat_oe_q))
      |-> $past(tick)) else $error("pin moved outside a slot"); // R2

  AST_DAT_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_oe_q |-> !dat_oe_q) else $error("data driven with clock released"); // R9

endmodule

// File: rtl/mgmt2w_seq.sv
module mgmt2w_seq
  import mgmt2w_pkg::*;
#(
  parameter logic [7:0] READ_CMD  = 8'hA9,
  parameter logic [7:0] WRITE_CMD = 8'hA8,
  parameter int         MAX_RETRY = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              req_valid,
  input  xfer_t             req_in,
  input  logic              dat_i,
  output pin_act_e          act,
  output logic              act_bit,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [WORD_W-1:0] rdata
);
  localparam int RW = $clog2(MAX_RETRY + 1);
  localparam logic [RW-1:0] RETRY_LAST = RW'(MAX_RETRY);
  localparam logic [IDX_W-1:0] LAST_BYTE = IDX_W'(4);
  localparam logic [IDX_W-1:0] ADDR_HI   = IDX_W'(2);

  seq_st_e            st_q, st_d;
  logic [STEP_W-1:0]  step_q, step_d;
  logic [IDX_W-1:0]   bit_q, bit_d;
  logic [IDX_W-1:0]   byte_q, byte_d;
  logic [RW-1:0]      retry_q, retry_d;
  logic [BYTE_W-1:0]  sh_q, sh_d;
  logic [WORD_W-1:0]  rx_q, rx_d;
  logic               hi_q, hi_d;
  logic               fail_q, fail_d;
  xfer_t              req_q, req_d;
  logic               done_q, done_d;
  logic               err_q, err_d;
  logic [WORD_W-1:0]  rdata_q, rdata_d;

  function automatic logic [BYTE_W-1:0] pick_byte(input xfer_t rq, input logic [IDX_W-1:0] idx);
    case (idx)
      3'd0:    pick_byte = rq.is_read ? READ_CMD : WRITE_CMD;
      3'd1:    pick_byte = rq.addr[7:0];
      3'd2:    pick_byte = rq.addr[15:8];
      3'd3:    pick_byte = rq.wdata[7:0];
      default: pick_byte = rq.wdata[15:8];
    endcase
  endfunction

  always_comb begin
    st_d    = st_q;
    step_d  = step_q;
    bit_d   = bit_q;
    byte_d  = byte_q;
    retry_d = retry_q;
    sh_d    = sh_q;
    rx_d    = rx_q;
    hi_d    = hi_q;
    fail_d  = fail_q;
    req_d   = req_q;
    rdata_d = rdata_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    act     = ACT_NONE;
    act_bit = 1'b0;

    if (st_q == ST_IDLE) begin
      if (req_valid) begin
        req_d  = req_in;
        st_d   = ST_START;
        step_d = '0;
        fail_d = 1'b0;
      end
    end else if (tick) begin
      unique case (st_q)
        ST_START: begin
          step_d = step_q + 1'b1;
          case (step_q)
            3'd0: act = ACT_OPEN;
            3'd1: act = ACT_CLK_HI;
            3'd2: act = ACT_CLK_LO;
            3'd3: act = ACT_CLK_HI;
            3'd4: act = ACT_DAT_LO;
            3'd5: act = ACT_CLK_LO;
            default: begin
              act    = ACT_DAT_HI;
              st_d   = ST_TX;
              step_d = '0;
              byte_d = '0;
              bit_d  = 3'd7;
              sh_d   = pick_byte(req_q, 3'd0);
            end
          endcase
        end

        ST_TX: begin
          step_d = step_q + 1'b1;
          case (step_q)
            3'd0: begin act = ACT_TX_BIT; act_bit = sh_q[BYTE_W-1]; end
            3'd1: act = ACT_CLK_HI;
            default: begin
              act    = ACT_CLK_LO;
              step_d = '0;
              if (bit_q == '0) begin
                retry_d = '0;
                if (!req_q.is_read && req_q.no_ack && byte_q == LAST_BYTE) st_d = ST_STOP;
                else                                                      st_d = ST_ACK;
              end else begin
                bit_d = bit_q - 1'b1;
                sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
              end
            end
          endcase
        end

        ST_ACK: begin
          if (step_q == '0) begin
            act    = ACT_RX_RISE;
            step_d = 3'd1;
          end else begin
            act    = ACT_RX_FALL_DRV;
            step_d = '0;
            if (!dat_i) begin
              if (req_q.is_read && byte_q == ADDR_HI) begin
                st_d  = ST_RX;
                bit_d = 3'd7;
                hi_d  = 1'b0;
              end else if (byte_q == LAST_BYTE) begin
                st_d = ST_STOP;
              end else begin
                st_d   = ST_TX;
                byte_d = byte_q + 1'b1;
                bit_d  = 3'd7;
                sh_d   = pick_byte(req_q, byte_q + 1'b1);
              end
            end else if (retry_q == RETRY_LAST) begin
              fail_d = 1'b1;
              st_d   = ST_STOP;
            end else begin
              retry_d = retry_q + 1'b1;
            end
          end
        end

        ST_RX: begin
          if (step_q == '0) begin
            act    = ACT_RX_RISE;
            step_d = 3'd1;
          end else begin
            act    = (bit_q == '0) ? ACT_RX_FALL_DRV : ACT_RX_FALL;
            step_d = '0;
            rx_d   = {rx_q[WORD_W-2:0], dat_i};
            if (bit_q == '0) st_d  = ST_MACK;
            else             bit_d = bit_q - 1'b1;
          end
        end

        ST_MACK: begin
          step_d = step_q + 1'b1;
          case (step_q)
            3'd0: begin act = ACT_TX_BIT; act_bit = hi_q; end
            3'd1: act = ACT_CLK_HI;
            default: begin
              act    = ACT_CLK_LO;
              step_d = '0;
              if (hi_q) begin
                st_d = ST_STOP;
              end else begin
                hi_d  = 1'b1;
                bit_d = 3'd7;
                st_d  = ST_RX;
              end
            end
          endcase
        end

        ST_STOP: begin
          step_d = step_q + 1'b1;
          case (step_q)
            3'd0: act = ACT_STOP_EDGE;
            3'd1: act = ACT_DAT_HI;
            3'd2: act = ACT_CLK_HI;
            3'd3: act = ACT_CLK_LO;
            3'd4: act = ACT_CLK_HI;
            3'd5: act = ACT_CLK_LO;
            3'd6: act = ACT_CLK_HI;
            default: begin
              act    = ACT_RELEASE;
              st_d   = ST_IDLE;
              step_d = '0;
              done_d = 1'b1;
              err_d  = fail_q;
              if (!fail_q && req_q.is_read)
                rdata_d = {rx_q[BYTE_W-1:0], rx_q[WORD_W-1:BYTE_W]};
            end
          endcase
        end

        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      step_q  <= '0;
      bit_q   <= '0;
      byte_q  <= '0;
      retry_q <= '0;
      sh_q    <= '0;
      rx_q    <= '0;
      hi_q    <= 1'b0;
      fail_q  <= 1'b0;
      req_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      st_q    <= st_d;
      step_q  <= step_d;
      bit_q   <= bit_d;
      byte_q  <= byte_d;
      retry_q <= retry_d;
      sh_q    <= sh_d;
      rx_q    <= rx_d;
      hi_q    <= hi_d;
      fail_q  <= fail_d;
      req_q   <= req_d;
      done_q  <= done_d;
      err_q   <= err_d;
      rdata_q <= rdata_d;
    end
  end

  assign busy  = (st_q != ST_IDLE);
  assign done  = done_q;
  assign err   = err_q;
  assign rdata = rdata_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q) else $error("done wider than one cycle"); // R11

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> done_q) else $error("error flag without done"); // R11

  AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    retry_q <= RETRY_LAST) else $error("retry count past its limit"); // R5

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata_q) |-> (done_q && !err_q)) else $error("read result moved outside a good completion"); // R6

  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (st_q == ST_IDLE)) else $error("done while still sequencing"); // R10

endmodule

// File: rtl/mgmt2w_master.sv
module mgmt2w_master
  import mgmt2w_pkg::*;
#(
  parameter int         HALF_CYCLES = 4,
  parameter logic [7:0] READ_CMD    = 8'hA9,
  parameter logic [7:0] WRITE_CMD   = 8'hA8,
  parameter int         MAX_RETRY   = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_read,
  input  logic        req_noack,
  input  logic [15:0] req_addr,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [15:0] rdata,
  output logic        mclk_o,
  output logic        mclk_oe,
  output logic        mdat_o,
  output logic        mdat_oe,
  input  logic        mdat_i
);
  // reset asserts at once, releases on a clock edge
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  xfer_t    req_bus;
  pin_act_e act;
  logic     act_bit;
  logic     tick;

  assign req_bus.is_read = req_read;
  assign req_bus.no_ack  = req_noack;
  assign req_bus.addr    = req_addr;
  assign req_bus.wdata   = req_wdata;

  mgmt2w_halfcnt #(.HALF_CYCLES(HALF_CYCLES)) u_halfcnt (
    .clk   (clk),
    .rst_n (core_rst_n),
    .run   (busy),
    .tick  (tick)
  );

  mgmt2w_seq #(
    .READ_CMD  (READ_CMD),
    .WRITE_CMD (WRITE_CMD),
    .MAX_RETRY (MAX_RETRY)
  ) u_seq (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .tick      (tick),
    .req_valid (req_valid),
    .req_in    (req_bus),
    .dat_i     (mdat_i),
    .act       (act),
    .act_bit   (act_bit),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .rdata     (rdata)
  );

  mgmt2w_pins u_pins (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .tick    (tick),
    .act     (act),
    .act_bit (act_bit),
    .clk_o   (mclk_o),
    .clk_oe  (mclk_oe),
    .dat_o   (mdat_o),
    .dat_oe  (mdat_oe)
  );

  AST_RELEASED_AT_DONE: assert property (@(posedge clk) disable iff (!core_rst_n)
    done |-> (!mclk_oe && !mdat_oe)) else $error("lines still driven at done"); // R9

  AST_BUSY_DRIVES: assert property (@(posedge clk) disable iff (!core_rst_n)
    (mclk_oe && !$fell(busy)) |-> busy) else $error("clock driven while idle"); // R10

endmodule

// File: tb/tb_mgmt2w_master.sv
module tb_mgmt2w_master;
  localparam int         H    = 2;
  localparam logic [7:0] RCMD = 8'hA9;
  localparam logic [7:0] WCMD = 8'hA8;
  localparam int         MAXR = 5;

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_read, req_noack;
  logic [15:0] req_addr, req_wdata;
  logic        busy, done, err;
  logic [15:0] rdata;
  logic        mclk_o, mclk_oe, mdat_o, mdat_oe, mdat_i;

  mgmt2w_master #(
    .HALF_CYCLES (H),
    .READ_CMD    (RCMD),
    .WRITE_CMD   (WCMD),
    .MAX_RETRY   (MAXR)
  ) dut (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_read (req_read), .req_noack (req_noack),
    .req_addr (req_addr), .req_wdata (req_wdata),
    .busy (busy), .done (done), .err (err), .rdata (rdata),
    .mclk_o (mclk_o), .mclk_oe (mclk_oe), .mdat_o (mdat_o), .mdat_oe (mdat_oe),
    .mdat_i (mdat_i)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk;
  int n_fail;
  bit mon_en;
  int cycles;

  // model state: pins {clk_oe, clk, dat_oe, dat}
  logic [3:0]  m_pins;
  logic [15:0] m_rdata;
  // expected per cycle: {busy, done, err, pins, rdata}
  logic [22:0] q_exp[$];
  bit          q_drv[$];
  string       q_tag[$];

  task automatic check(input string tag, input logic [22:0] act, input logic [22:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h exp %h", tag, act, exp);
    end
  endtask

  task automatic push_step(input logic [3:0] np, input bit drv, input string tag);
    for (int i = 0; i < H; i++) begin
      q_exp.push_back({3'b100, m_pins, m_rdata});
      q_drv.push_back(drv);
      q_tag.push_back(tag);
    end
    m_pins = np;
  endtask

  task automatic set_clk(input bit v, input string tag);
    push_step({m_pins[3], v, m_pins[1:0]}, 1'b1, tag);
  endtask

  task automatic set_dat(input bit v, input string tag);
    push_step({m_pins[3:1], v}, 1'b1, tag);
  endtask

  task automatic tx_bits(input logic [7:0] b, input int n, input string tag);
    for (int i = n - 1; i >= 0; i--) begin
      push_step({m_pins[3:2], 1'b1, b[i]}, 1'b1, tag);
      set_clk(1'b1, tag);
      set_clk(1'b0, tag);
    end
  endtask

  task automatic rx_bit(input bit v, input bit last, input string tag);
    push_step({m_pins[3], 1'b1, 1'b0, m_pins[0]}, v, tag);
    if (last) push_step({m_pins[3], 1'b0, 1'b1, 1'b0}, v, tag);
    else      push_step({m_pins[3], 1'b0, m_pins[1:0]}, v, tag);
  endtask

  task automatic ack_poll(input int nacks, output bit ok);
    string tg;
    tg = (nacks > MAXR) ? "R5" : "R4";
    ok = 1'b0;
    for (int k = 0; k <= MAXR; k++) begin
      rx_bit(k < nacks, 1'b1, tg);
      if (k >= nacks) begin ok = 1'b1; break; end
    end
  endtask

  task automatic rx_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) rx_bit(b[i], i == 0, "R6");
  endtask

  // builds the full expected cycle stream of one transaction
  task automatic gen_txn(input bit rd, input bit noack, input logic [15:0] addr,
                         input logic [15:0] wd, input int nk[5],
                         input logic [7:0] lo, input logic [7:0] hi);
    bit ok;
    push_step(4'b1011, 1'b1, "R2");
    set_clk(1'b1, "R2"); set_clk(1'b0, "R2"); set_clk(1'b1, "R2");
    set_dat(1'b0, "R2"); set_clk(1'b0, "R2"); set_dat(1'b1, "R2");
    tx_bits(rd ? RCMD : WCMD, 8, "R12");
    ack_poll(nk[0], ok);
    if (ok) begin tx_bits(addr[7:0], 8, "R3"); ack_poll(nk[1], ok); end
    if (ok) begin tx_bits(addr[15:8], 8, "R3"); ack_poll(nk[2], ok); end
    if (ok) begin
      if (rd) begin
        rx_byte(lo); tx_bits(8'h00, 1, "R6");
        rx_byte(hi); tx_bits(8'h01, 1, "R6");
      end else begin
        tx_bits(wd[7:0], 8, "R7");
        ack_poll(nk[3], ok);
        if (ok) begin
          tx_bits(wd[15:8], 8, noack ? "R8" : "R7");
          if (!noack) ack_poll(nk[4], ok);
        end
      end
    end
    push_step({m_pins[3], 1'b1, m_pins[1], 1'b0}, 1'b1, "R9");
    set_dat(1'b1, "R9"); set_clk(1'b1, "R9"); set_clk(1'b0, "R9");
    set_clk(1'b1, "R9"); set_clk(1'b0, "R9"); set_clk(1'b1, "R9");
    push_step({1'b0, m_pins[2], 1'b0, m_pins[0]}, 1'b1, "R9");
    if (ok && rd) m_rdata = {hi, lo};
    q_exp.push_back({1'b0, 1'b1, !ok, m_pins, m_rdata});
    q_drv.push_back(1'b1);
    q_tag.push_back(!ok ? "R5" : (rd ? "R6" : "R11"));
  endtask

  task automatic run_txn(input bit rd, input bit noack, input logic [15:0] addr,
                         input logic [15:0] wd, input int nk[5],
                         input logic [7:0] lo, input logic [7:0] hi, input bit sneak);
    @(negedge clk); #1;
    req_valid = 1'b1; req_read = rd; req_noack = noack;
    req_addr = addr; req_wdata = wd;
    gen_txn(rd, noack, addr, wd, nk, lo, hi);
    @(negedge clk); #1;
    req_valid = 1'b0;
    if (sneak) begin
      // R10: a request while busy must leave the stream untouched
      repeat (60) @(negedge clk);
      #1;
      req_valid = 1'b1; req_read = 1'b1; req_noack = 1'b0;
      req_addr = 16'h0F0F; req_wdata = 16'h7777;
      repeat (10) @(negedge clk);
      #1;
      req_valid = 1'b0;
    end
    while (q_exp.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // monitor: compare outputs and drive the device data line each cycle
  initial begin
    logic [22:0] e;
    bit          d;
    string       t;
    mdat_i = 1'b1;
    cycles = 0;
    forever begin
      @(negedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: got %0d cycles exp completion", cycles);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
      if (mon_en) begin
        if (q_exp.size() != 0) begin
          e = q_exp.pop_front(); d = q_drv.pop_front(); t = q_tag.pop_front();
        end else begin
          e = {3'b000, m_pins, m_rdata}; d = 1'b1; t = "R10";
        end
        check(t, {busy, done, err, mclk_oe, mclk_o, mdat_oe, mdat_o, rdata}, e);
        mdat_i = d;
      end
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; mon_en = 1'b0;
    m_pins = 4'b0000; m_rdata = 16'h0000;
    req_valid = 1'b0; req_read = 1'b0; req_noack = 1'b0;
    req_addr = '0; req_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check("R1", {busy, done, err, mclk_oe, mclk_o, mdat_oe, mdat_o, rdata}, 23'd0);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_en = 1'b1;
    repeat (2) @(negedge clk);

    // R7 R12: plain write, every byte acknowledged at once
    run_txn(1'b0, 1'b0, 16'h1234, 16'hBEEF, '{0, 0, 0, 0, 0}, 8'h00, 8'h00, 1'b0);
    // R6 R4: read with two refusals on the low address byte
    run_txn(1'b1, 1'b0, 16'h00F0, 16'h0000, '{0, 2, 0, 0, 0}, 8'h5A, 8'hC3, 1'b0);
    // R8 R10: write without the final poll, with a request while busy
    run_txn(1'b0, 1'b1, 16'h8000, 16'h0001, '{0, 0, 0, 0, 0}, 8'h00, 8'h00, 1'b1);
    // R5: read aborted on the high address byte, result kept
    run_txn(1'b1, 1'b0, 16'h4321, 16'h0000, '{0, 0, 6, 0, 0}, 8'h11, 8'h22, 1'b0);
    // R4: five refusals then acknowledge still succeeds
    run_txn(1'b0, 1'b0, 16'hA5A5, 16'h0F0F, '{0, 0, 0, 5, 1}, 8'h00, 8'h00, 1'b0);
    // R5: write aborted on the command byte
    run_txn(1'b0, 1'b0, 16'h0001, 16'h0002, '{6, 0, 0, 0, 0}, 8'h00, 8'h00, 1'b0);
    // R6: read of all-ones / all-zero data
    run_txn(1'b1, 1'b0, 16'hFFFF, 16'h0000, '{0, 0, 0, 0, 0}, 8'hFF, 8'h00, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule